// File: doc/BRIEF.md
# Transmit/Receive Descriptor Ring Controller

This block owns a table of 32-bit buffer descriptors shared by the transmit and receive directions. A host fills the table and sets a boundary register through a small register port. Table indices below the boundary form the transmit ring. Indices at or above it form the receive ring. Each direction keeps a ring pointer. A descriptor is serviced once its ready flag is set (for receive, a frame must also be reported on the frame-start input). The block then moves the payload as 32-bit DMA words. Each word is raised on the request line of that direction and closed by the matching acknowledge. When the last word has been acknowledged, the block writes the descriptor back with ready cleared and moves the pointer.

Descriptor layout: length in bits 31:16, ready in bit 15, wrap in bit 14, control-frame flag in bit 13. A transmit descriptor with the control flag set fetches no payload. Instead it emits a one-cycle pause indication that carries the length field as the pause timer. A receive pause frame always moves 64 bytes. One engine serves one descriptor at a time. When both directions have work in the same idle cycle, receive goes first.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset no request or pause indication is active, and reading the boundary register (select = 1) returns RX_BASE_RST (64 by default).
- R2: The descriptor fields are length [31:16], ready [15], wrap [14] and control [13]. A descriptor whose bit 15 is 0 starts no request and no pause indication.
- R3: A ready transmit descriptor with bit 13 clear and length N bytes produces exactly ceil(N/4) words on tx_req/tx_ack. dma_word counts 0,1,2... within the frame, and a request stays high until it is acknowledged.
- R4: A ready transmit descriptor with bit 13 set produces exactly one single-cycle pause_valid with pause_time equal to bits 31:16, and no tx_req.
- R5: A ready receive descriptor plus a reported frame of length N produces ceil(N/4) words on rx_req/rx_ack. A reported pause frame produces 16 words, whatever its length input.
- R6: Only after the last word is acknowledged is the descriptor written back with bit 15 cleared. For transmit, the other bits are unchanged. For receive, bits 31:16 hold the moved length (64 for pause) and bit 13 is set exactly for a pause frame.
- R7: After service a pointer increments. It returns to the start of its region (0 for transmit, the boundary for receive) when the served descriptor had bit 14 set, or when it was the last index of the region (boundary-1 for transmit, the top table index for receive).
- R8: Writing the boundary register moves the receive pointer to the new boundary and the transmit pointer to 0. Transmit serves only indices below the boundary and receive only indices at or above it.
- R9: When a transmit and a receive descriptor become serviceable in the same cycle, the receive one is served first.
- R10: tx_req and rx_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_base_sel | input | 1 | 1 selects the boundary register, 0 the descriptor table |
| host_addr | input | IDX_W | Descriptor index for host access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the selected register or descriptor |
| rx_frame_start | input | 1 | Pulse: a received frame awaits a descriptor |
| rx_frame_len | input | 16 | Byte length of the reported frame |
| rx_frame_pause | input | 1 | Reported frame is a pause frame |
| tx_req | output | 1 | Transmit DMA word request |
| tx_ack | input | 1 | Transmit DMA word acknowledge |
| rx_req | output | 1 | Receive DMA word request |
| rx_ack | input | 1 | Receive DMA word acknowledge |
| dma_word | output | 15 | Index of the current word within the frame |
| active_idx | output | IDX_W | Descriptor index being served |
| pause_valid | output | 1 | One-cycle pause indication |
| pause_time | output | 16 | Pause timer value |

## Verification
A pointer that is wrong shows up at the next service: active_idx reports the wrong descriptor on its first request, or a descriptor is served again or skipped. This happens within a few cycles of the ready flag being set. A wrong word count shows as an extra or missing acknowledge, or as a dma_word sequence that does not match the expected one, in the same frame. A bad write-back is seen at the next host read of that descriptor: a ready bit still set, or a receive length or control flag that is wrong. A wrong priority shows in which request line rises first.

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl #(
  parameter int IDX_W       = 7,
  parameter int RX_BASE_RST = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_base_sel,
  input  logic [IDX_W-1:0] host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             rx_frame_start,
  input  logic [15:0]      rx_frame_len,
  input  logic             rx_frame_pause,
  output logic             tx_req,
  input  logic             tx_ack,
  output logic             rx_req,
  input  logic             rx_ack,
  output logic [14:0]      dma_word,
  output logic [IDX_W-1:0] active_idx,
  output logic             pause_valid,
  output logic [15:0]      pause_time
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] TOP = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;

  logic [31:0]      tbl [DEPTH];
  logic [IDX_W-1:0] base, tx_ptr, rx_ptr, cur;
  st_t              state;
  logic             is_rx, rx_pend, rx_pause_q;
  logic [15:0]      rx_len_q;
  logic [14:0]      cnt, words;

  wire [31:0] tx_d  = tbl[tx_ptr];
  wire [31:0] rx_d  = tbl[rx_ptr];
  wire [31:0] cur_d = tbl[cur];
  wire [15:0] rx_pkt_len = rx_pause_q ? 16'd64 : rx_len_q;
  wire tx_go = tx_d[15] && (tx_ptr < base);
  wire rx_go = rx_pend && rx_d[15] && (rx_ptr >= base);

  function automatic logic [14:0] nwords(input logic [15:0] len);
    logic [16:0] s;
    s = {1'b0, len} + 17'd3;
    return s[16:2];
  endfunction

  wire [14:0] rx_words = nwords(rx_pkt_len);
  wire [14:0] tx_words = nwords(tx_d[31:16]);
  wire [IDX_W-1:0] tx_next = (cur_d[14] || cur == base - 1'b1) ? '0 : cur + 1'b1;
  wire [IDX_W-1:0] rx_next = (cur_d[14] || cur == TOP) ? base : cur + 1'b1;
  wire cur_ack = is_rx ? rx_ack : tx_ack;

  assign host_rdata = host_base_sel ? 32'(base) : tbl[host_addr];
  assign tx_req     = (state == S_XFER) && !is_rx;
  assign rx_req     = (state == S_XFER) && is_rx;
  assign dma_word   = cnt;
  assign active_idx = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      base        <= IDX_W'(RX_BASE_RST);
      tx_ptr      <= '0;
      rx_ptr      <= IDX_W'(RX_BASE_RST);
      cur         <= '0;
      state       <= S_IDLE;
      is_rx       <= 1'b0;
      rx_pend     <= 1'b0;
      rx_pause_q  <= 1'b0;
      rx_len_q    <= '0;
      cnt         <= '0;
      words       <= '0;
      pause_valid <= 1'b0;
      pause_time  <= '0;
    end else begin
      pause_valid <= 1'b0;
      if (rx_frame_start && !rx_pend) begin
        rx_pend    <= 1'b1;
        rx_len_q   <= rx_frame_len;
        rx_pause_q <= rx_frame_pause;
      end
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (rx_go) begin
            is_rx <= 1'b1;
            cur   <= rx_ptr;
            words <= rx_words;
            state <= (rx_words == '0) ? S_DONE : S_XFER;
          end else if (tx_go) begin
            is_rx <= 1'b0;
            cur   <= tx_ptr;
            words <= tx_words;
            if (tx_d[13]) begin
              pause_valid <= 1'b1;
              pause_time  <= tx_d[31:16];
              state       <= S_DONE;
            end else begin
              state <= (tx_words == '0) ? S_DONE : S_XFER;
            end
          end
        end
        S_XFER: begin
          if (cur_ack) begin
            if (cnt == words - 1'b1) state <= S_DONE;
            else cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (is_rx) begin
            tbl[cur] <= {rx_pkt_len, 1'b0, cur_d[14], rx_pause_q, cur_d[12:0]};
            rx_ptr   <= rx_next;
            rx_pend  <= 1'b0;
          end else begin
            tbl[cur][15] <= 1'b0;
            tx_ptr       <= tx_next;
          end
          state <= S_IDLE;
        end
      endcase
      if (host_we) begin
        if (host_base_sel) begin
          base   <= host_wdata[IDX_W-1:0];
          tx_ptr <= '0;
          rx_ptr <= host_wdata[IDX_W-1:0];
        end else begin
          tbl[host_addr] <= host_wdata;
        end
      end
    end
  end

  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !(tx_req && rx_req));
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_req && !tx_ack |=> tx_req);
  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_req && !rx_ack |=> rx_req);
  // R4
  pause_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) pause_valid |=> !pause_valid);
  // R4
  pause_nodma_chk: assert property (@(posedge clk) disable iff (!rst_n) pause_valid |-> !tx_req && !rx_req);
  // R6
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && !host_we) |=> !tbl[$past(cur)][15]);
  // R8
  base_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_base_sel |=> (rx_ptr == $past(host_wdata[IDX_W-1:0])) && (tx_ptr == '0));
endmodule

// File: tb/bd_ring_ctrl_tb.sv
module bd_ring_ctrl_tb;
  localparam int IDX_W = 7;
  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_base_sel = 0;
  logic [IDX_W-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic rx_frame_start = 0, rx_frame_pause = 0;
  logic [15:0] rx_frame_len = '0;
  logic tx_req, rx_req, tx_ack = 0, rx_ack = 0, pause_valid;
  logic [14:0] dma_word;
  logic [IDX_W-1:0] active_idx;
  logic [15:0] pause_time;

  int n_chk = 0, n_fail = 0;
  int n_tx, n_rx, n_pause, word_err, first_dir, n_log;
  int idx_log [8];
  int fw;
  logic [15:0] last_pt;
  logic prev_tx, prev_rx;

  always #4 clk = ~clk;

  bd_ring_ctrl #(.IDX_W(IDX_W), .RX_BASE_RST(64)) u_dut (
    .clk, .rst_n, .host_we, .host_base_sel, .host_addr, .host_wdata, .host_rdata,
    .rx_frame_start, .rx_frame_len, .rx_frame_pause,
    .tx_req, .tx_ack, .rx_req, .rx_ack, .dma_word, .active_idx,
    .pause_valid, .pause_time);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] desc(input logic [15:0] len, input bit rdy, input bit wrp, input bit ctl);
    return {len, rdy, wrp, ctl, 13'd0};
  endfunction

  task automatic wr(input bit sel, input int addr, input logic [31:0] d, input bit rxs = 0,
                    input logic [15:0] rl = 0, input bit rp = 0);
    @(negedge clk);
    host_we = 1; host_base_sel = sel; host_addr = IDX_W'(addr); host_wdata = d;
    rx_frame_start = rxs; rx_frame_len = rl; rx_frame_pause = rp;
    tx_ack = 0; rx_ack = 0;
    @(negedge clk);
    host_we = 0; rx_frame_start = 0;
  endtask

  task automatic rd(input bit sel, input int addr, output logic [31:0] d);
    @(negedge clk);
    host_base_sel = sel; host_addr = IDX_W'(addr);
    #1 d = host_rdata;
  endtask

  task automatic clr();
    n_tx = 0; n_rx = 0; n_pause = 0; word_err = 0; first_dir = 0; n_log = 0;
    prev_tx = 0; prev_rx = 0; fw = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_ack = 0; rx_ack = 0;
      if (pause_valid) begin
        n_pause++; last_pt = pause_time;
        if (n_log < 8) idx_log[n_log++] = active_idx;
        if (first_dir == 0) first_dir = 1;
      end
      if (tx_req) begin
        if (!prev_tx) begin
          fw = 0;
          if (n_log < 8) idx_log[n_log++] = active_idx;
          if (first_dir == 0) first_dir = 1;
        end
        if (dma_word != 15'(fw)) word_err++;
        fw++; n_tx++; tx_ack = 1;
      end
      if (rx_req) begin
        if (!prev_rx) begin
          fw = 0;
          if (n_log < 8) idx_log[n_log++] = active_idx;
          if (first_dir == 0) first_dir = 2;
        end
        if (dma_word != 15'(fw)) word_err++;
        fw++; n_rx++; rx_ack = 1;
      end
      prev_tx = tx_req; prev_rx = rx_req;
    end
    @(negedge clk);
    tx_ack = 0; rx_ack = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(!tx_req && !rx_req && !pause_valid, "R1 idle outputs", {tx_req, rx_req, pause_valid}, 0);
    rd(1, 0, d);
    check(d == 64, "R1 boundary reset", d, 64);
  endtask

  task automatic t_not_ready();
    clr(); wr(0, 0, desc(8, 0, 0, 0)); run(20);
    check(n_tx == 0 && n_pause == 0, "R2 not-ready ignored", n_tx + n_pause, 0);
  endtask

  task automatic t_tx_frame();
    logic [31:0] d;
    clr(); wr(0, 0, desc(10, 1, 0, 0)); run(30);
    check(n_tx == 3, "R3 10 bytes -> 3 words", n_tx, 3);
    check(word_err == 0, "R3 word index sequence", word_err, 0);
    rd(0, 0, d);
    check(d == desc(10, 0, 0, 0), "R6 tx writeback", d, desc(10, 0, 0, 0));
    clr(); wr(0, 1, desc(16, 1, 0, 0)); run(30);
    check(n_tx == 4 && idx_log[0] == 1, "R7 increment to 1", idx_log[0], 1);
  endtask

  task automatic t_pause();
    clr(); wr(0, 2, desc(16'h1234, 1, 1, 1)); run(20);
    check(n_pause == 1, "R4 one pause pulse", n_pause, 1);
    check(last_pt == 16'h1234, "R4 pause timer", last_pt, 16'h1234);
    check(n_tx == 0, "R4 no payload", n_tx, 0);
    clr(); wr(0, 0, desc(4, 1, 0, 0)); run(20);
    check(n_tx == 1 && idx_log[0] == 0, "R7 wrap flag to 0", idx_log[0], 0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    clr(); wr(0, 64, desc(0, 1, 0, 0)); wr(0, 100, 0, 1, 7, 0); run(30);
    check(n_rx == 2, "R5 7 bytes -> 2 words", n_rx, 2);
    check(idx_log[0] == 64 && word_err == 0, "R5 rx at boundary", idx_log[0], 64);
    rd(0, 64, d);
    check(d == desc(7, 0, 0, 0), "R6 rx writeback", d, desc(7, 0, 0, 0));
    clr(); wr(0, 65, desc(0, 1, 0, 0)); wr(0, 100, 0, 1, 3, 1); run(40);
    check(n_rx == 16, "R5 pause frame 16 words", n_rx, 16);
    rd(0, 65, d);
    check(d == desc(64, 0, 0, 1), "R6 rx pause writeback", d, desc(64, 0, 0, 1));
  endtask

  task automatic t_priority();
    clr(); wr(0, 66, desc(0, 1, 0, 0));
    wr(0, 1, desc(8, 1, 0, 0), 1, 8, 0); run(40);
    check(first_dir == 2, "R9 receive first", first_dir, 2);
    check(n_tx == 2 && n_rx == 2, "R9 both served", n_tx * 100 + n_rx, 202);
  endtask

  task automatic t_region();
    clr(); wr(1, 0, 4);
    for (int k = 0; k < 4; k++) wr(0, k, desc(4, 1, 0, 0));
    run(30);
    check(n_tx == 4 && idx_log[0] == 0 && idx_log[3] == 3, "R8 tx from 0 after boundary write", idx_log[3], 3);
    clr(); wr(0, 4, desc(8, 0, 0, 0)); wr(0, 0, desc(4, 1, 0, 0)); run(20);
    check(n_tx == 1 && idx_log[0] == 0, "R7 tx region end back to 0", idx_log[0], 0);
    clr(); wr(0, 4, desc(0, 1, 0, 0)); wr(0, 100, 0, 1, 4, 0); run(20);
    check(n_rx == 1 && idx_log[0] == 4, "R8 rx at new boundary", idx_log[0], 4);
    clr(); wr(1, 0, 126);
    wr(0, 126, desc(0, 1, 0, 0)); wr(0, 127, desc(0, 1, 0, 0)); wr(0, 100, 0, 1, 4, 0); run(15);
    wr(0, 100, 0, 1, 4, 0); run(15);
    wr(0, 126, desc(0, 1, 0, 0)); wr(0, 100, 0, 1, 4, 0); run(15);
    check(n_log == 3 && idx_log[1] == 127 && idx_log[2] == 126, "R7 rx top back to boundary", idx_log[2], 126);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_not_ready();
    t_tx_frame();
    t_pause();
    t_rx();
    t_priority();
    t_region();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule